// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler with Timer Tap

This block derives single-cycle clock-enable strobes from one core clock. Two peripheral buses, two timer groups and one converter use these strobes. A single free-running binary counter runs continuously. Each strobe comes from one tap of that counter: tap k fires when the low k counter bits are all zero. Each bus has its own 3-bit divide select, which picks the tap that drives the bus strobe.

The timer strobe behind a bus comes from the next faster tap. When the bus is divided, the timer therefore runs at twice the bus rate. The timer can never run faster than the core, so a bus at divide 1 gives a timer strobe equal to the bus strobe. The converter strobe divides the second bus strobe by a further six.

A new divide select takes effect only at the counter's full wraparound. A change of select therefore never produces a shortened or stretched strobe period. No clock is gated or generated; every output is an enable in the core clock domain.

Top module: `bus_strobe_gen`

## Requirements
- R1: A bus select value picks the bus divide: values 0, 1, 2 and 3 give divide 1; 4 gives 2; 5 gives 4; 6 gives 8; 7 gives 16. The bus strobe pulses once per divide-count core cycles.
- R2: When a bus divide is greater than 1, its timer strobe pulses at twice the bus strobe rate. With bus divide 16, the timer divide is 8.
- R3: When a bus divide is 1 or 2, its timer strobe is high on every core cycle.
- R4: The converter strobe pulses on every sixth pulse of the second bus strobe, counted from the first bus pulse after reset.
- R5: A select change is adopted only on the cycle after the chain counter reaches its all-ones value. Until then the previous divide stays in force.
- R6: After reset, both bus divides are 1 whatever the select inputs are. The chain counter starts at zero, so all five strobes are high on the first cycle after reset.
- R7: Every bus and timer strobe is high when the chain counter is zero. Every bus pulse coincides with a pulse of its timer strobe.
- R8: A strobe whose divide is 1 is held high on every core cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus0_sel_i | input | 3 | Divide select for the first bus |
| bus1_sel_i | input | 3 | Divide select for the second bus |
| bus0_en_o | output | 1 | First bus clock enable |
| bus1_en_o | output | 1 | Second bus clock enable |
| tmr0_en_o | output | 1 | Timer enable behind the first bus |
| tmr1_en_o | output | 1 | Timer enable behind the second bus |
| conv_en_o | output | 1 | Converter enable, second bus divided by six |

## Verification
The hardest case to reach from the ports is a select change that lands in the middle of a counter period. Its effect on the output only shows as the absence of a truncated period. The bench resets the block, counts core cycles to place the change at a known counter value, and counts pulses over the rest of the period and the next one. With a select applied too early, the count would differ from the count a wrap-aligned change gives. Counting windows are a multiple of every strobe period, including the converter's, so pulse counts do not depend on phase.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;
  localparam int SEL_W   = 3;
  localparam int CHAIN_W = 4;                    // longest divide = 2**CHAIN_W
  localparam int SH_W    = $clog2(CHAIN_W + 1);

  typedef logic [SEL_W-1:0] div_sel_t;
  typedef logic [SH_W-1:0]  shift_t;

  // 0..3 -> divide 1, 4..7 -> divide 2..16
  function automatic shift_t sel_to_shift(div_sel_t s);
    if (s < div_sel_t'(4)) return shift_t'(0);
    return shift_t'(s - div_sel_t'(3));
  endfunction

  function automatic shift_t timer_shift(shift_t bus_sh);
    return (bus_sh == shift_t'(0)) ? shift_t'(0) : shift_t'(bus_sh - shift_t'(1));
  endfunction
endpackage

// File: rtl/div_chain.sv
module div_chain #(
  parameter int CHAIN_W = bus_strobe_pkg::CHAIN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [CHAIN_W-1:0] cnt_o,
  output logic               wrap_o
);
  logic [CHAIN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;
endmodule

// File: rtl/tap_select.sv
module tap_select
  import bus_strobe_pkg::*;
#(
  parameter int CHAIN_W = bus_strobe_pkg::CHAIN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CHAIN_W-1:0] cnt_i,
  input  logic               wrap_i,
  input  div_sel_t           sel_i,
  output div_sel_t           sel_q_o,
  output logic               bus_en_o,
  output logic               tmr_en_o
);
  logic [CHAIN_W:0] tap;
  div_sel_t         sel_q;
  shift_t           bus_sh, tmr_sh;

  // tap k fires when the low k chain bits are zero
  for (genvar k = 0; k <= CHAIN_W; k++) begin : g_tap
    localparam logic [CHAIN_W-1:0] MASK = CHAIN_W'((32'd1 << k) - 32'd1);
    assign tap[k] = ((cnt_i & MASK) == '0);
  end

  // select only moves at full wraparound
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (wrap_i) sel_q <= sel_i;
  end

  always_comb begin
    bus_sh = sel_to_shift(sel_q);
    tmr_sh = timer_shift(bus_sh);
  end

  assign bus_en_o = tap[bus_sh];
  assign tmr_en_o = tap[tmr_sh];
  assign sel_q_o  = sel_q;
endmodule

// File: rtl/conv_div.sv
module conv_div #(
  parameter int DIV = 6,
  localparam int CW = $clog2(DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
  end

  assign en_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int CONV_DIV = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] bus0_sel_i,
  input  logic [2:0] bus1_sel_i,
  output logic       bus0_en_o,
  output logic       bus1_en_o,
  output logic       tmr0_en_o,
  output logic       tmr1_en_o,
  output logic       conv_en_o
);
  localparam int NBUS = 2;

  logic [CHAIN_W-1:0] chain_cnt;
  logic               chain_wrap;
  div_sel_t           sel_in [NBUS];
  div_sel_t           sel_q  [NBUS];
  logic [NBUS-1:0]    bus_en, tmr_en;

  assign sel_in[0] = bus0_sel_i;
  assign sel_in[1] = bus1_sel_i;

  div_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (chain_cnt),
    .wrap_o (chain_wrap)
  );

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    tap_select #(.CHAIN_W(CHAIN_W)) u_tap (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_i    (chain_cnt),
      .wrap_i   (chain_wrap),
      .sel_i    (sel_in[g]),
      .sel_q_o  (sel_q[g]),
      .bus_en_o (bus_en[g]),
      .tmr_en_o (tmr_en[g])
    );
  end

  conv_div #(.DIV(CONV_DIV)) u_conv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (bus_en[1]),
    .en_o   (conv_en_o)
  );

  assign bus0_en_o = bus_en[0];
  assign bus1_en_o = bus_en[1];
  assign tmr0_en_o = tmr_en[0];
  assign tmr1_en_o = tmr_en[1];
endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk
  import bus_strobe_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CHAIN_W-1:0] cnt_i,
  input div_sel_t           sel0_q_i,
  input div_sel_t           sel1_q_i,
  input logic               bus0_en_i,
  input logic               bus1_en_i,
  input logic               tmr0_en_i,
  input logic               tmr1_en_i,
  input logic               conv_en_i
);
  localparam logic [CHAIN_W-1:0] CNT_MAX = '1;

  // R7
  zero_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> (bus0_en_i && bus1_en_i && tmr0_en_i && tmr1_en_i));

  // R7
  bus_in_tmr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus0_en_i |-> tmr0_en_i) and (bus1_en_i |-> tmr1_en_i));

  // R3
  fast_tmr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel0_q_i <= div_sel_t'(4)) |-> tmr0_en_i) and ((sel1_q_i <= div_sel_t'(4)) |-> tmr1_en_i));

  // R4
  conv_on_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_en_i |-> bus1_en_i);

  // R5
  sel_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sel0_q_i) || !$stable(sel1_q_i)) |-> ($past(cnt_i) == CNT_MAX));

  // R8
  div1_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel0_q_i < div_sel_t'(4)) |-> bus0_en_i);
endmodule

bind bus_strobe_gen bus_strobe_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (chain_cnt),
  .sel0_q_i  (sel_q[0]),
  .sel1_q_i  (sel_q[1]),
  .bus0_en_i (bus0_en_o),
  .bus1_en_i (bus1_en_o),
  .tmr0_en_i (tmr0_en_o),
  .tmr1_en_i (tmr1_en_o),
  .conv_en_i (conv_en_o)
);

// File: tb/bus_strobe_gen_tb.sv
`timescale 1ns/1ps
module bus_strobe_gen_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] bus0_sel = '0, bus1_sel = '0;
  logic       bus0_en, bus1_en, tmr0_en, tmr1_en, conv_en;

  int checks = 0, fails = 0;
  int c_b0, c_b1, c_t0, c_t1, c_cv;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_strobe_gen u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .bus0_sel_i (bus0_sel),
    .bus1_sel_i (bus1_sel),
    .bus0_en_o  (bus0_en),
    .bus1_en_o  (bus1_en),
    .tmr0_en_o  (tmr0_en),
    .tmr1_en_o  (tmr1_en),
    .conv_en_o  (conv_en)
  );

  typedef struct packed {
    logic [2:0] s0, s1;
    logic [7:0] b0, t0, b1, t1, cv;
  } vec_t;

  localparam int WIN = 192;   // multiple of every strobe period
  localparam int NV  = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 8'd192, 8'd192, 8'd192, 8'd192, 8'd32},
    '{3'd4, 3'd5, 8'd96,  8'd192, 8'd48,  8'd96,  8'd8},
    '{3'd5, 3'd6, 8'd48,  8'd96,  8'd24,  8'd48,  8'd4},
    '{3'd6, 3'd7, 8'd24,  8'd48,  8'd12,  8'd24,  8'd2},
    '{3'd7, 3'd4, 8'd12,  8'd24,  8'd96,  8'd192, 8'd16},
    '{3'd3, 3'd2, 8'd192, 8'd192, 8'd192, 8'd192, 8'd32},
    '{3'd7, 3'd7, 8'd12,  8'd24,  8'd12,  8'd24,  8'd2},
    '{3'd4, 3'd0, 8'd96,  8'd192, 8'd192, 8'd192, 8'd32}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // leaves the bench at the negedge where the chain counter is zero
  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // samples the current negedge plus n-1 more
  task automatic measure(int n);
    c_b0 = 0; c_b1 = 0; c_t0 = 0; c_t1 = 0; c_cv = 0;
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge clk);
      c_b0 += int'(bus0_en); c_b1 += int'(bus1_en);
      c_t0 += int'(tmr0_en); c_t1 += int'(tmr1_en);
      c_cv += int'(conv_en);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    // R6 R7: first cycle after reset, all strobes high
    do_reset();
    check("R6 bus0", int'(bus0_en), 1);
    check("R6 bus1", int'(bus1_en), 1);
    check("R7 tmr0", int'(tmr0_en), 1);
    check("R7 tmr1", int'(tmr1_en), 1);
    check("R6 conv", int'(conv_en), 1);
    // R4 R8: conv silent for 5 cycles, then pulses; divide-1 bus high throughout
    @(negedge clk);
    measure(5);
    check("R4 conv gap", c_cv, 0);
    check("R8 bus0 div1", c_b0, 5);
    @(negedge clk);
    check("R4 conv sixth", int'(conv_en), 1);

    // R1 R2 R3 R4: table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      bus0_sel = VECS[v].s0;
      bus1_sel = VECS[v].s1;
      repeat (40) @(negedge clk);
      measure(WIN);
      check("R1 bus0", c_b0, int'(VECS[v].b0));
      check("R1 bus1", c_b1, int'(VECS[v].b1));
      check((VECS[v].t0 == 8'd192) ? "R3 tmr0" : "R2 tmr0", c_t0, int'(VECS[v].t0));
      check((VECS[v].t1 == 8'd192) ? "R3 tmr1" : "R2 tmr1", c_t1, int'(VECS[v].t1));
      check("R4 conv", c_cv, int'(VECS[v].cv));
    end

    // R6: reset forces divide 1 although inputs select 16
    bus0_sel = 3'd7; bus1_sel = 3'd7;
    do_reset();
    measure(16);
    check("R6 bus0 after reset", c_b0, 16);
    check("R6 bus1 after reset", c_b1, 16);

    // R5: change mid-period at counter 3, takes effect at counter 16
    bus0_sel = 3'd0; bus1_sel = 3'd0;
    do_reset();
    repeat (3) @(negedge clk);
    bus0_sel = 3'd7;
    measure(29);            // counter values 3..31
    check("R5 bus0 mid change", c_b0, 14);
    check("R5 tmr0 mid change", c_t0, 15);
    check("R5 bus1 untouched", c_b1, 29);

    done = 1'b1;
    finish_run();
  end
endmodule